// File: doc/BRIEF.md
# Single-Bus Accumulator Processor with Hardwired Control

This block is a small accumulator machine. Six registers (program counter, instruction register, memory address register, memory data register, accumulator and a sum holding register) share one internal data bus, and a single-port word memory sits behind the address and data registers. A hardwired control unit produces every control point. A one-hot step counter and the decoded opcode feed sum-of-products equations, and each product term is a step ANDed with an opcode, with the accumulator-zero flag as a further term in some cases.

Four instructions exist: load, add, store and branch-if-accumulator-zero. Every instruction first runs the same four fetch steps. It then runs its own short execute schedule, and the counter goes back to the first step. A preload port fills the memory while the machine is held in reset. A combinational peek port reads any memory word. The program counter, the accumulator and the current step are brought out so that programs can be checked against a model.

Top module: `acc_cpu_top`

## Requirements
- R1: A synchronous reset clears the program counter and the accumulator and sets the step output to the first step (value 8'b0000_0001). The reset state holds for as long as reset stays high.
- R2: The step output is always one-hot. Steps 0 to 4 advance one per clock. At the end of step 1 the program counter increments, so it shows the new value from step 2 onward.
- R3: The instruction word has the opcode in bits [7:6] and the memory address in bits [5:0]. Load is opcode 2'b00. It copies the addressed word into the accumulator, takes 7 clocks, and then returns to step 0.
- R4: Add is opcode 2'b01. It adds the addressed word to the accumulator modulo 256, takes 8 clocks, and then returns to step 0.
- R5: Store is opcode 2'b10. It writes the accumulator to the addressed word, leaves the accumulator unchanged, and takes 7 clocks.
- R6: Branch-if-zero is opcode 2'b11. When the accumulator is zero it loads the address field into the program counter. It takes 6 clocks.
- R7: Branch-if-zero with a nonzero accumulator leaves the program counter at the incremented fetch value.
- R8: At most one source drives the shared bus in any step.
- R9: The preload port writes memory while reset is held. The peek port returns the addressed word in the same cycle.
- R10: The program counter wraps from 63 to 0 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 6 | Preload word address |
| pre_data | input | 8 | Preload write data |
| peek_addr | input | 6 | Peek read address |
| peek_data | output | 8 | Word at peek_addr (combinational) |
| pc_o | output | 6 | Program counter |
| acc_o | output | 8 | Accumulator |
| step_o | output | 8 | One-hot current time step |

## Verification
The bench builds the block with its default values: an 8-bit word, a 2-bit opcode (which gives 64 words of memory) and 8 steps. With a 6-bit address a short program can place code at the top of memory. That makes the program-counter wrap from 63 to 0 reachable, and a taken branch can land there. An 8-bit accumulator lets a single add overflow, so the modulo result can be checked. It also makes a zero accumulator easy to reach by loading a zero word, which exercises both outcomes of the branch.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_ADD   = 2'b01,
      OP_STORE = 2'b10,
      OP_BRZ   = 2'b11
   } opcode_e;

   // one bit per control point of the datapath
   typedef struct packed {
      logic pc_drv;     // program counter onto bus
      logic ira_drv;    // instruction address field onto bus
      logic mdr_drv;    // data register onto bus
      logic acc_drv;    // accumulator onto bus
      logic tmp_drv;    // sum register onto bus
      logic mar_ld;     // address register from bus
      logic mdr_ld;     // data register from bus
      logic ir_ld;      // instruction register from bus
      logic pc_ld;      // program counter from bus
      logic acc_ld;     // accumulator from bus
      logic sum_ld;     // sum register gets bus + data register
      logic pc_inc;     // program counter increment
      logic mem_rd;     // data register from memory
      logic mem_wr;     // memory from data register
      logic step_clr;   // return counter to step 0
   } ctl_t;

   localparam int NUM_SRC = 5;

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq #(
   parameter int NSTEP = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   output logic [NSTEP-1:0] step
);

   generate
      if (NSTEP < 8) begin : g_bad_nstep
         $error("acc_cpu_seq: NSTEP must be at least 8");
      end
   endgenerate

   localparam logic [NSTEP-1:0] FIRST = {{(NSTEP-1){1'b0}}, 1'b1};

   logic [NSTEP-1:0] nxt;

   always_comb begin
      if (clr) nxt = FIRST;
      else     nxt = {step[NSTEP-2:0], step[NSTEP-1]};
   end

   always_ff @(posedge clk) begin
      if (rst) step <= FIRST;
      else     step <= nxt;
   end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int NSTEP = 8,
   parameter int OP_W  = 2
) (
   input  logic [NSTEP-1:0] step,
   input  logic [OP_W-1:0]  op,
   input  logic             acc_zero,
   output ctl_t             ctl
);

   localparam int NOPS = 2 ** OP_W;

   generate
      if (OP_W != 2) begin : g_bad_opw
         $error("acc_cpu_ctrl: equations cover exactly four opcodes");
      end
   endgenerate

   logic [NOPS-1:0] dec;

   generate
      for (genvar g = 0; g < NOPS; g++) begin : g_dec
         assign dec[g] = (op == OP_W'(g));
      end
   endgenerate

   logic is_ld, is_ad, is_st, is_bz;
   logic t0, t1, t2, t4, t5, t6, t7;

   assign is_ld = dec[OP_LOAD];
   assign is_ad = dec[OP_ADD];
   assign is_st = dec[OP_STORE];
   assign is_bz = dec[OP_BRZ];

   assign t0 = step[0];
   assign t1 = step[1];
   assign t2 = step[2];
   assign t4 = step[4];
   assign t5 = step[5];
   assign t6 = step[6];
   assign t7 = step[7];

   logic bz_take;
   assign bz_take = is_bz & acc_zero & t4;

   // sum-of-products control equations
   always_comb begin
      ctl.pc_drv   = t0;
      ctl.ira_drv  = (is_ld & t4) | (is_ad & t4) | (is_st & t4) | bz_take;
      ctl.mdr_drv  = t2 | (is_ld & t6);
      ctl.acc_drv  = (is_st & t5) | (is_ad & t6);
      ctl.tmp_drv  = is_ad & t7;
      ctl.mar_ld   = t0 | (is_ld & t4) | (is_ad & t4) | (is_st & t4);
      ctl.mdr_ld   = is_st & t5;
      ctl.ir_ld    = t2;
      ctl.pc_ld    = bz_take;
      ctl.acc_ld   = (is_ld & t6) | (is_ad & t7);
      ctl.sum_ld   = is_ad & t6;
      ctl.pc_inc   = t1;
      ctl.mem_rd   = t1 | (is_ld & t5) | (is_ad & t5);
      ctl.mem_wr   = is_st & t6;
      ctl.step_clr = (is_ld & t6) | (is_ad & t7) | (is_st & t6) | (is_bz & t5);
   end

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OP_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  ctl_t                       ctl,
   input  logic                       pre_we,
   input  logic [DATA_W-OP_W-1:0]     pre_addr,
   input  logic [DATA_W-1:0]          pre_data,
   input  logic [DATA_W-OP_W-1:0]     peek_addr,
   output logic [DATA_W-1:0]          peek_data,
   output logic [DATA_W-1:0]          ir_q,
   output logic [DATA_W-OP_W-1:0]     pc_q,
   output logic [DATA_W-1:0]          acc_q,
   output logic [NUM_SRC-1:0]         drv_en
);

   localparam int ADDR_W = DATA_W - OP_W;
   localparam int DEPTH  = 2 ** ADDR_W;

   generate
      if (DATA_W <= OP_W) begin : g_bad_width
         $error("acc_cpu_dp: word must be wider than the opcode");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] mdr_q;
   logic [DATA_W-1:0] tmp_q;
   logic [DATA_W-1:0] bus;

   // bus sources, indexed in the order of drv_en
   logic [DATA_W-1:0] src    [NUM_SRC];
   logic [DATA_W-1:0] masked [NUM_SRC];

   assign drv_en = {ctl.tmp_drv, ctl.acc_drv, ctl.mdr_drv, ctl.ira_drv, ctl.pc_drv};

   assign src[0] = DATA_W'(pc_q);
   assign src[1] = DATA_W'(ir_q[ADDR_W-1:0]);
   assign src[2] = mdr_q;
   assign src[3] = acc_q;
   assign src[4] = tmp_q;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_busmask
         assign masked[g] = src[g] & {DATA_W{drv_en[g]}};
      end
   endgenerate

   always_comb begin
      bus = '0;
      for (int i = 0; i < NUM_SRC; i++) bus = bus | masked[i];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         ir_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
         acc_q <= '0;
         tmp_q <= '0;
      end else begin
         if (ctl.pc_ld)       pc_q <= bus[ADDR_W-1:0];
         else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
         if (ctl.ir_ld)  ir_q  <= bus;
         if (ctl.mar_ld) mar_q <= bus[ADDR_W-1:0];
         if (ctl.mem_rd)      mdr_q <= mem[mar_q];
         else if (ctl.mdr_ld) mdr_q <= bus;
         if (ctl.acc_ld) acc_q <= bus;
         if (ctl.sum_ld) tmp_q <= bus + mdr_q;
      end
   end

   always_ff @(posedge clk) begin
      if (pre_we)                  mem[pre_addr] <= pre_data;
      else if (!rst && ctl.mem_wr) mem[mar_q]    <= mdr_q;
   end

   assign peek_data = mem[peek_addr];

endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OP_W   = 2,
   parameter int NSTEP  = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   pre_we,
   input  logic [DATA_W-OP_W-1:0] pre_addr,
   input  logic [DATA_W-1:0]      pre_data,
   input  logic [DATA_W-OP_W-1:0] peek_addr,
   output logic [DATA_W-1:0]      peek_data,
   output logic [DATA_W-OP_W-1:0] pc_o,
   output logic [DATA_W-1:0]      acc_o,
   output logic [NSTEP-1:0]       step_o
);

   ctl_t              ctl;
   logic [DATA_W-1:0] ir_q;
   logic [NUM_SRC-1:0] drv_en;
   logic              acc_zero;
   logic [OP_W-1:0]   cur_op;

   assign acc_zero = (acc_o == '0);
   assign cur_op   = ir_q[DATA_W-1 -: OP_W];

   acc_cpu_seq #(.NSTEP(NSTEP)) u_seq (
      .clk  (clk),
      .rst  (rst),
      .clr  (ctl.step_clr),
      .step (step_o)
   );

   acc_cpu_ctrl #(.NSTEP(NSTEP), .OP_W(OP_W)) u_ctrl (
      .step     (step_o),
      .op       (cur_op),
      .acc_zero (acc_zero),
      .ctl      (ctl)
   );

   acc_cpu_dp #(.DATA_W(DATA_W), .OP_W(OP_W)) u_dp (
      .clk       (clk),
      .rst       (rst),
      .ctl       (ctl),
      .pre_we    (pre_we),
      .pre_addr  (pre_addr),
      .pre_data  (pre_data),
      .peek_addr (peek_addr),
      .peek_data (peek_data),
      .ir_q      (ir_q),
      .pc_q      (pc_o),
      .acc_q     (acc_o),
      .drv_en    (drv_en)
   );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
   parameter int DATA_W = 8,
   parameter int OP_W   = 2,
   parameter int NSTEP  = 8,
   parameter int NSRC   = 5
) (
   input logic                   clk,
   input logic                   rst,
   input logic [DATA_W-OP_W-1:0] pc_o,
   input logic [DATA_W-1:0]      acc_o,
   input logic [NSTEP-1:0]       step_o,
   input logic [DATA_W-1:0]      ir_q,
   input logic [NSRC-1:0]        drv_en
);

   localparam int ADDR_W = DATA_W - OP_W;

   logic [OP_W-1:0] op;
   assign op = ir_q[DATA_W-1 -: OP_W];

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (pc_o == '0 && acc_o == '0 && step_o == NSTEP'(1)));

   assert_step_onehot_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot(step_o));

   assert_pc_increment_R2: assert property (@(posedge clk) disable iff (rst)
      step_o[1] |=> pc_o == $past(pc_o) + 1'b1);

   assert_decode_advance_R2: assert property (@(posedge clk) disable iff (rst)
      step_o[3] |=> step_o[4]);

   assert_load_return_R3: assert property (@(posedge clk) disable iff (rst)
      (step_o[6] && op == 2'b00) |=> step_o[0]);

   assert_add_return_R4: assert property (@(posedge clk) disable iff (rst)
      (step_o[7] && op == 2'b01) |=> step_o[0]);

   assert_store_keeps_acc_R5: assert property (@(posedge clk) disable iff (rst)
      (step_o[6] && op == 2'b10) |=> $stable(acc_o));

   assert_branch_taken_R6: assert property (@(posedge clk) disable iff (rst)
      (step_o[4] && op == 2'b11 && acc_o == '0) |=> pc_o == $past(ir_q[ADDR_W-1:0]));

   assert_branch_not_taken_R7: assert property (@(posedge clk) disable iff (rst)
      (step_o[4] && op == 2'b11 && acc_o != '0) |=> $stable(pc_o));

   assert_single_driver_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(drv_en));

endmodule

bind acc_cpu_top acc_cpu_chk #(
   .DATA_W (DATA_W),
   .OP_W   (OP_W),
   .NSTEP  (NSTEP),
   .NSRC   (acc_cpu_pkg::NUM_SRC)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .pc_o   (pc_o),
   .acc_o  (acc_o),
   .step_o (step_o),
   .ir_q   (ir_q),
   .drv_en (drv_en)
);

// File: tb/sim_acc_cpu_top.sv
`timescale 1ns/1ps
module sim_acc_cpu_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pre_we = 1'b0;
   logic [5:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic [5:0] peek_addr = '0;
   logic [7:0] peek_data;
   logic [5:0] pc_o;
   logic [7:0] acc_o;
   logic [7:0] step_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   acc_cpu_top u0 (
      .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
      .pre_data(pre_data), .peek_addr(peek_addr), .peek_data(peek_data),
      .pc_o(pc_o), .acc_o(acc_o), .step_o(step_o)
   );

   typedef struct packed {
      logic [1:0] op;
      logic [3:0] cyc;
      logic [7:0] acc;
      logic [5:0] pc;
   } vec_t;

   // expected state after each instruction of the program, in run order
   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{2'b00, 4'd7, 8'h05, 6'd1},   // load 40
      '{2'b01, 4'd8, 8'h03, 6'd2},   // add 41 (wraps)
      '{2'b10, 4'd7, 8'h03, 6'd3},   // store 44
      '{2'b11, 4'd6, 8'h03, 6'd4},   // brz 10, not taken
      '{2'b00, 4'd7, 8'h00, 6'd5},   // load 43
      '{2'b11, 4'd6, 8'h00, 6'd20},  // brz 20, taken
      '{2'b00, 4'd7, 8'h03, 6'd21},  // load 44
      '{2'b01, 4'd8, 8'h06, 6'd22},  // add 42
      '{2'b10, 4'd7, 8'h06, 6'd23},  // store 45
      '{2'b00, 4'd7, 8'h00, 6'd24},  // load 43
      '{2'b11, 4'd6, 8'h00, 6'd62},  // brz 62, taken
      '{2'b01, 4'd8, 8'h03, 6'd63},  // add 42
      '{2'b11, 4'd6, 8'h03, 6'd0}    // brz 0, not taken, pc wraps
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [1:0] op, input logic [7:0] acc_before);
      case (op)
         2'b00: return "R3 load";
         2'b01: return "R4 add";
         2'b10: return "R5 store";
         default: return (acc_before == 0) ? "R6 branch taken" : "R7 branch not taken R10";
      endcase
   endfunction

   task automatic poke(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      pre_we = 1'b1; pre_addr = a; pre_data = d;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] acc_prev;
      for (int a = 0; a < 64; a++) poke(a[5:0], 8'h00);
      poke(6'd0,  8'h28); poke(6'd1,  8'h69); poke(6'd2,  8'hAC);
      poke(6'd3,  8'hCA); poke(6'd4,  8'h2B); poke(6'd5,  8'hD4);
      poke(6'd20, 8'h2C); poke(6'd21, 8'h6A); poke(6'd22, 8'hAD);
      poke(6'd23, 8'h2B); poke(6'd24, 8'hFE); poke(6'd62, 8'h6A);
      poke(6'd63, 8'hC0);
      poke(6'd40, 8'h05); poke(6'd41, 8'hFE); poke(6'd42, 8'h03);
      poke(6'd43, 8'h00);
      @(negedge clk);
      pre_we = 1'b0;

      // R9: preload readable through peek port
      peek_addr = 6'd41; #1;
      chk("R9 peek after preload", peek_data, 8'hFE);
      // R1: reset state
      @(negedge clk);
      chk("R1 reset pc", pc_o, 0);
      chk("R1 reset acc", acc_o, 0);
      chk("R1 reset step", step_o, 8'h01);

      rst = 1'b0;
      acc_prev = 8'h00;
      for (int i = 0; i < NVEC; i++) begin
         for (int k = 1; k <= int'(VECS[i].cyc); k++) begin
            @(negedge clk);
            if (i == 0 && k < int'(VECS[i].cyc))
               chk("R2 step sequence", step_o, 8'h01 << k);
            if (i == 0 && k == 2)
               chk("R2 pc after fetch read", pc_o, 1);
         end
         chk({tag_of(VECS[i].op, acc_prev), " step"}, step_o, 8'h01);
         chk({tag_of(VECS[i].op, acc_prev), " acc"}, acc_o, VECS[i].acc);
         chk({tag_of(VECS[i].op, acc_prev), " pc"}, pc_o, VECS[i].pc);
         acc_prev = VECS[i].acc;
      end

      // R5: stored words visible in memory
      peek_addr = 6'd44; #1;
      chk("R5 store to 44", peek_data, 8'h03);
      peek_addr = 6'd45; #1;
      chk("R5 store to 45", peek_data, 8'h06);

      // R1: reset in the middle of an instruction
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid-run reset pc", pc_o, 0);
      chk("R1 mid-run reset acc", acc_o, 0);
      chk("R1 mid-run reset step", step_o, 8'h01);
      @(negedge clk);
      chk("R1 reset held step", step_o, 8'h01);
      finish_run();
   end

endmodule